// File: doc/BRIEF.md
# Serial Bus Acknowledge/Busy Controller

This block runs the acknowledge and busy handshake for one channel of a clocked serial bus. An 8-bit shift engine, which lies outside this block, moves the data. This block watches the bus clock and decides when the data line is pulled low, either to acknowledge a byte or to hold the bus busy. It also records whether the far side acknowledged.

Software controls the block through one small control register. The register has a one-shot acknowledge trigger, an automatic-acknowledge enable, a busy enable and a read-only acknowledge-seen flag. The shift engine supplies a start pulse and a level that goes high when the byte has finished.

The serial clock arrives asynchronously. It passes through a synchronizer chain in the system clock domain, and all bus-side decisions are taken on the detected falling and rising edges. The line itself appears as a pull-low request output and a sampled input. The pad lies outside the block.

Top module: `sbus_ackbusy_ctrl`

## Requirements
- R1: Writing 1 to control bit 2 while the channel is enabled pulls the line low from the next serial-clock falling edge until the falling edge after it. The bit then clears itself, so no second acknowledge follows.
- R2: The pending one-shot trigger (bit 2) is dropped when a transfer starts or while the channel enable is low. A later falling edge then produces no acknowledge.
- R3: With automatic acknowledge (bit 3) at 0, the 9th falling edge after a transfer start does not pull the line.
- R4: With bit 3 at 1 before the byte completes, the line is pulled from the 9th falling edge after the transfer start until the 10th.
- R5: Writing bit 3 from 0 to 1 while the transfer-complete level is high pulls the line from the next falling edge for one clock period. Bit 3 then still reads 1.
- R6: A rising serial-clock edge with the transfer-complete level high and the data line low sets the acknowledge-seen flag (output `ack_seen`, control bit 5). A rising edge with the transfer-complete level low leaves the flag clear.
- R7: The acknowledge-seen flag clears when the channel is disabled. It also clears at the first falling edge after a transfer start once busy is released.
- R8: With busy enable (bit 4) at 1, the line stays pulled from the falling edge that ends an acknowledge onward.
- R9: Clearing bit 4 while busy is driven releases the line at the next falling edge.
- R10: A transfer start releases busy and any acknowledge at once, and bit 4 keeps its value of 1.
- R11: Control bits 0, 1 and 2 always read as 0. Bits 6 and 7 also read as 0.
- R12: While the channel enable is low, the line is never pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Control register write data |
| reg_rdata | output | REG_W | Control register read data |
| xfer_start | input | 1 | One-cycle transfer start pulse |
| xfer_done | input | 1 | High once the byte transfer has completed |
| sck | input | 1 | Serial clock, asynchronous, idle high |
| sda_in | input | 1 | Sampled data line |
| sda_pull | output | 1 | Request to pull the data line low |
| ack_seen | output | 1 | Acknowledge detected |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer, an acknowledge slot on the 9th falling edge and an 8-bit register. These values keep a full byte-plus-acknowledge sequence short enough to step through edge by edge. They also let every falling edge of the acknowledge and busy sequences be checked against the line, including the edges just before and after the slot.

// File: rtl/sbab_pkg.sv
package sbab_pkg;
   localparam int unsigned F_REL  = 0;
   localparam int unsigned F_CMD  = 1;
   localparam int unsigned F_TRIG = 2;
   localparam int unsigned F_AUTO = 3;
   localparam int unsigned F_BUSY = 4;
   localparam int unsigned F_SEEN = 5;
   localparam int unsigned F_MIN_W = 6;
endpackage

// File: rtl/sbab_edge_sync.sv
module sbab_edge_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   output logic fall_p,
   output logic rise_p
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= IDLE;
            else        chain <= sck;
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= {STAGES{IDLE}};
            else        chain <= {chain[STAGES-2:0], sck};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= IDLE;
      else        last_q <= chain[STAGES-1];

   assign fall_p = last_q & ~chain[STAGES-1];
   assign rise_p = ~last_q & chain[STAGES-1];
endmodule

// File: rtl/sbab_slot_cnt.sv
module sbab_slot_cnt #(
   parameter int unsigned SLOT = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_en,
   input  logic xfer_start,
   input  logic fall_p,
   output logic slot_hit
);
   localparam int unsigned CW = $clog2(SLOT + 1);
   localparam logic [CW-1:0] LAST = CW'(SLOT - 1);

   logic [CW-1:0] cnt;
   logic          active;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (!chan_en) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (xfer_start) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (fall_p && active) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) active <= 1'b0;
      end

   assign slot_hit = fall_p & active & (cnt == LAST);
endmodule

// File: rtl/sbab_ctrl_regs.sv
module sbab_ctrl_regs #(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             xfer_start,
   input  logic             xfer_done,
   input  logic             ack_begin,
   input  logic             ack_end,
   output logic             trig_q,
   output logic             late_q,
   output logic             auto_q,
   output logic             busy_en_q
);
   import sbab_pkg::*;

   logic w_trig, w_auto, w_busy;
   assign w_trig = reg_wr & reg_wdata[F_TRIG];
   assign w_auto = reg_wdata[F_AUTO];
   assign w_busy = reg_wdata[F_BUSY];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         auto_q    <= 1'b0;
         busy_en_q <= 1'b0;
      end else if (reg_wr) begin
         auto_q    <= w_auto;
         busy_en_q <= w_busy;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   trig_q <= 1'b0;
      else if (!chan_en || xfer_start) trig_q <= 1'b0;
      else if (w_trig)              trig_q <= 1'b1;
      else if (ack_end)             trig_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      late_q <= 1'b0;
      else if (!chan_en || xfer_start) late_q <= 1'b0;
      else if (reg_wr && w_auto && !auto_q && xfer_done) late_q <= 1'b1;
      else if (ack_begin)              late_q <= 1'b0;

   // R2
   trig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start || !chan_en) |=> !trig_q);
endmodule

// File: rtl/sbus_ackbusy_ctrl.sv
module sbus_ackbusy_ctrl #(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ACK_SLOT    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             xfer_start,
   input  logic             xfer_done,
   input  logic             sck,
   input  logic             sda_in,
   output logic             sda_pull,
   output logic             ack_seen
);
   import sbab_pkg::*;

   generate
      if (REG_W < F_MIN_W) begin : g_bad_w
         $error("REG_W too small for control fields");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (ACK_SLOT < 2) begin : g_bad_slot
         $error("ACK_SLOT must be at least 2");
      end
   endgenerate

   logic fall_p, rise_p, slot_hit;
   logic trig_q, late_q, auto_q, busy_en_q;
   logic ack_drive, busy_drive, clr_pend;
   logic ack_begin, ack_end;

   sbab_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(sck), .fall_p(fall_p), .rise_p(rise_p));

   sbab_slot_cnt #(.SLOT(ACK_SLOT)) u_slot (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_start(xfer_start),
      .fall_p(fall_p), .slot_hit(slot_hit));

   sbab_ctrl_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .xfer_start(xfer_start), .xfer_done(xfer_done),
      .ack_begin(ack_begin), .ack_end(ack_end), .trig_q(trig_q),
      .late_q(late_q), .auto_q(auto_q), .busy_en_q(busy_en_q));

   assign ack_begin = chan_en & ~xfer_start & fall_p & ~ack_drive &
                      (trig_q | late_q | (slot_hit & auto_q));
   assign ack_end   = chan_en & ~xfer_start & fall_p & ack_drive;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      ack_drive <= 1'b0;
      else if (!chan_en || xfer_start) ack_drive <= 1'b0;
      else if (ack_end)                ack_drive <= 1'b0;
      else if (ack_begin)              ack_drive <= 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      busy_drive <= 1'b0;
      else if (!chan_en || xfer_start) busy_drive <= 1'b0;
      else if (ack_end)                busy_drive <= busy_en_q;
      else if (fall_p && !busy_en_q)   busy_drive <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         clr_pend <= 1'b0;
      else if (!chan_en)                  clr_pend <= 1'b0;
      else if (xfer_start)                clr_pend <= 1'b1;
      else if (fall_p && !busy_drive)     clr_pend <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                 ack_seen <= 1'b0;
      else if (!chan_en)                          ack_seen <= 1'b0;
      else if (rise_p && xfer_done && !sda_in)    ack_seen <= 1'b1;
      else if (fall_p && clr_pend && !busy_drive) ack_seen <= 1'b0;

   assign sda_pull = ack_drive | busy_drive;

   always_comb begin
      reg_rdata         = '0;
      reg_rdata[F_AUTO] = auto_q;
      reg_rdata[F_BUSY] = busy_en_q;
      reg_rdata[F_SEEN] = ack_seen;
   end

   // R12
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !sda_pull);
   // R10
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !sda_pull);
   // R1
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !fall_p && !xfer_start) |=> $stable(sda_pull));
   // R6
   seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_seen) |-> ($past(rise_p) && $past(xfer_done) && !$past(sda_in)));
   // R8
   busy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_end && busy_en_q) |=> sda_pull);
endmodule

// File: tb/sbus_ackbusy_ctrl_test.sv
module sbus_ackbusy_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_en = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       xfer_start = 1'b0;
   logic       xfer_done = 1'b0;
   logic       sck = 1'b1;
   logic       sda_in = 1'b1;
   logic       sda_pull;
   logic       ack_seen;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct { bit exp; string tag; } item_t;
   item_t q[$];

   always #10 clk = ~clk;

   sbus_ackbusy_ctrl uut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
      .xfer_done(xfer_done), .sck(sck), .sda_in(sda_in), .sda_pull(sda_pull),
      .ack_seen(ack_seen));

   // monitor: pops expected line values and compares
   initial forever begin
      @(posedge clk);
      if (q.size() != 0) begin
         item_t it;
         it = q.pop_front();
         #5;
         total++;
         if (sda_pull !== it.exp) begin
            bad++;
            $display("FAIL %s: sda_pull=%0b expected %0b", it.tag, sda_pull, it.exp);
         end
      end
   end

   task automatic expect_line(input bit e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      q.push_back(it);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_rd(input logic [7:0] e, input string tag);
      total++;
      if (reg_rdata !== e) begin
         bad++;
         $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata, e);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic start_pulse();
      @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // one serial clock period: fall, check line, rise
   task automatic sck_cycle(input bit e, input string tag);
      @(negedge clk); sck = 1'b0;
      repeat (6) @(negedge clk);
      expect_line(e, tag);
      sck = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic sck_plain();
      @(negedge clk); sck = 1'b0;
      repeat (6) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_rd(8'h00, "reset R11");
      expect_line(1'b0, "reset R12");
      chan_en = 1'b1;

      // R11: trigger bits read as zero
      wr(8'h07);
      check_rd(8'h00, "R11 trigger bits");
      sck_cycle(1'b1, "R1 ack after write");
      sck_cycle(1'b0, "R1 ack one period");
      sck_cycle(1'b0, "R1 trigger self-cleared");

      // R8, R9: busy follows ack, released by clearing enable
      wr(8'h14);
      sck_cycle(1'b1, "R8 ack");
      sck_cycle(1'b1, "R8 busy after ack");
      sck_cycle(1'b1, "R8 busy held");
      wr(8'h00);
      sck_cycle(1'b0, "R9 busy released");

      // R10: start releases busy, enable bit stays
      wr(8'h14);
      sck_cycle(1'b1, "R10 setup ack");
      sck_cycle(1'b1, "R10 setup busy");
      start_pulse();
      expect_line(1'b0, "R10 start releases");
      check_rd(8'h10, "R10 busy enable kept");
      wr(8'h00);

      // R4: automatic ack on 9th falling edge
      wr(8'h08);
      start_pulse();
      for (int i = 1; i <= 7; i++) sck_plain();
      sck_cycle(1'b0, "R4 8th edge quiet");
      sck_cycle(1'b1, "R4 9th edge ack");
      sck_cycle(1'b0, "R4 10th edge release");
      wr(8'h00);

      // R3: automatic disabled
      start_pulse();
      for (int i = 1; i <= 8; i++) sck_plain();
      sck_cycle(1'b0, "R3 9th edge no ack");

      // R5: automatic set after completion
      xfer_done = 1'b1;
      wr(8'h08);
      sck_cycle(1'b1, "R5 late ack");
      sck_cycle(1'b0, "R5 late ack one period");
      check_rd(8'h08, "R5 auto bit kept");
      wr(8'h00);
      xfer_done = 1'b0;

      // R6, R7: detection and clear after start
      xfer_done = 1'b1; sda_in = 1'b0;
      sck_plain();
      check_rd(8'h20, "R6 ack seen bit");
      total++;
      if (ack_seen !== 1'b1) begin
         bad++; $display("FAIL R6 ack_seen port: got %0b expected 1", ack_seen);
      end
      xfer_done = 1'b0; sda_in = 1'b1;
      start_pulse();
      check_rd(8'h20, "R7 held until edge");
      sck_plain();
      check_rd(8'h00, "R7 cleared after start");

      // R6: no detection before completion
      sda_in = 1'b0;
      sck_plain();
      sda_in = 1'b1;
      check_rd(8'h00, "R6 not set before done");

      // R7, R12, R2: channel disable
      xfer_done = 1'b1; sda_in = 1'b0;
      sck_plain();
      xfer_done = 1'b0; sda_in = 1'b1;
      check_rd(8'h20, "R7 setup seen");
      chan_en = 1'b0;
      repeat (2) @(negedge clk);
      check_rd(8'h00, "R7 cleared by disable");
      wr(8'h04);
      sck_cycle(1'b0, "R12 no pull when disabled");
      chan_en = 1'b1;
      sck_cycle(1'b0, "R2 trigger dropped by disable");

      // R2: start drops trigger
      wr(8'h04);
      start_pulse();
      sck_cycle(1'b0, "R2 trigger dropped by start");
      sck_cycle(1'b0, "R2 still quiet");

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule